// File: doc/BRIEF.md
# RTC Interrupt Flag Aggregator

This block gathers event strobes from the timekeeping sources of a real-time clock and turns them into two active-low interrupt outputs. There are eight sources: the once-per-second tick, countdown timer A, watchdog timer A, countdown timer B, the alarm match, the battery switch-over detector, the battery-low detector and the clock offset correction pulse. Each source has a sticky flag and an enable bit. A small synchronous register port lets software set the enables, choose the output modes, read the flags and clear the flags that software is allowed to clear.

The second tick and timer A share one mode bit, and timer B has its own. Each mode bit chooses between a fixed-length low pulse and a level that follows the flag. Every other source drives a level that follows its flag. The second interrupt output carries timer B only. The first interrupt output shares a pin with a free-running low-frequency clock. After reset the pin carries the clock and the interrupt is held off the pin. The flags keep updating while the clock is on the pin.

Top module: `rtc_irq_collector`

## Requirements
- R1: After reset the enable register and the mode register read as 0, all flags are 0, `irq2_n_o` is 1, `rdata_o` is 0 and `irq1_pin_o` equals `clk32k_i`.
- R2: An event strobe on `ev_i[k]` sets flag k at the next clock edge. The flag bits are 0 second tick, 1 countdown A, 2 watchdog A, 3 countdown B, 4 alarm, 5 battery switch-over, 6 battery low, 7 offset correction.
- R3: In level mode, when enable bit k (register 0) and flag k are both set and mode bit 2 (register 2) is 1, `irq1_pin_o` is 0. It returns to 1 in the cycle after the flag clears.
- R4: A write to register 1 clears each flag whose data bit is 1, for bits 0, 1, 3, 4 and 5. Data bits 2, 6 and 7 have no effect on the flags.
- R5: If a flag-clear write and a new event for the same source arrive in the same cycle, the flag stays set.
- R6: A read of register 1 returns the flags as they were before the read and clears the watchdog A flag (bit 2), unless a new watchdog event arrives in that same cycle.
- R7: The battery-low flag (bit 6) ignores writes. It clears only on a `batt_ok_i` strobe.
- R8: The offset correction flag (bit 7) is set for exactly the one cycle after its strobe.
- R9: Mode bit 0 puts the second tick and countdown A into pulse mode, and mode bit 1 does the same for countdown B. In pulse mode an enabled event drives its output low for exactly PULSE_CYCLES cycles starting at the edge that captures the event. The flag stays set afterwards.
- R10: `irq2_n_o` is driven only by countdown B, gated by mode bit 3. It follows the countdown B flag in level mode and the pulse in pulse mode. No other source affects it.
- R11: While mode bit 2 is 0, `irq1_pin_o` equals `clk32k_i` whatever the interrupt state, and the flags still capture events.
- R12: A read registers its data on the clock edge at the end of the read cycle: register 0 gives the enables, 1 the flags, 2 the mode in bits 3:0, and 3 gives 0. `rdata_o` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 8 | One-cycle event strobes, one per source |
| batt_ok_i | input | 1 | Strobe: battery reported replaced |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| clk32k_i | input | 1 | Low-frequency clock for the shared pin |
| irq1_pin_o | output | 1 | Shared pin: active-low first interrupt or the clock |
| irq2_n_o | output | 1 | Active-low second interrupt (countdown B) |

## Verification
Two situations are hard to reach from the ports. The first is a software clear or a watchdog-clearing read that lands in the same cycle as a new event for the same flag. The second is the exact length of a pulse-mode output. The bench drives the clear write and the event strobe together from one task call, then reads the flags back. It counts cycles from the capturing edge and checks the output on every cycle of the pulse window and on the first cycle after it. The flags keep updating while the pin carries the clock, and the bench shows this by raising events in clock mode and then reading the flag register.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int NSRC    = 8;
    localparam int ADDR_W  = 2;
    localparam int MODE_W  = 4;
    localparam int NPULSE  = 4;

    // flag / enable bit positions
    localparam int SRC_SEC = 0;
    localparam int SRC_TMA = 1;
    localparam int SRC_WDG = 2;
    localparam int SRC_TMB = 3;
    localparam int SRC_ALM = 4;
    localparam int SRC_BSW = 5;
    localparam int SRC_BLO = 6;
    localparam int SRC_OFS = 7;

    // mode register bits
    localparam int MD_PULSE_A = 0;
    localparam int MD_PULSE_B = 1;
    localparam int MD_PIN_IRQ = 2;
    localparam int MD_IRQ2_EN = 3;

    localparam logic [ADDR_W-1:0] REG_EN   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MODE = 2'd2;

    // flags software may clear by writing 1
    localparam logic [NSRC-1:0] SW_CLR_MASK = 8'b0011_1011;

    typedef struct packed {
        logic [NSRC-1:0]   en;
        logic [MODE_W-1:0] mode;
    } cfg_t;
endpackage

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic [NSRC-1:0]   flags_i,
    output cfg_t              cfg_o,
    output logic [NSRC-1:0]   rdata_o
);
    typedef struct packed {
        cfg_t            cfg;
        logic [NSRC-1:0] rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            case (addr_i)
                REG_EN:   s_d.cfg.en   = wdata_i;
                REG_MODE: s_d.cfg.mode = wdata_i[MODE_W-1:0];
                default:  ;
            endcase
        end
        if (rd_en_i) begin
            case (addr_i)
                REG_EN:   s_d.rdata = s_q.cfg.en;
                REG_FLAG: s_d.rdata = flags_i;
                REG_MODE: s_d.rdata = {{(NSRC-MODE_W){1'b0}}, s_q.cfg.mode};
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o   = s_q.cfg;
    assign rdata_o = s_q.rdata;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic [NSRC-1:0] sw_clr_i,
    input  logic            rd_clr_i,
    input  logic            batt_ok_i,
    output logic [NSRC-1:0] flags_o
);
    typedef struct packed {
        logic [NSRC-1:0] flags;
    } flag_st_t;

    flag_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.flags = s_q.flags & ~(sw_clr_i & SW_CLR_MASK);
        if (rd_clr_i)  s_d.flags[SRC_WDG] = 1'b0;
        if (batt_ok_i) s_d.flags[SRC_BLO] = 1'b0;
        s_d.flags[SRC_OFS] = 1'b0;       // offset indicator lives one cycle
        s_d.flags = s_d.flags | ev_i;    // new event beats any clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_st_t;

    pulse_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig_i)
            s_d.cnt = CNT_W'(CYCLES);
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = (s_q.cnt != '0);
endmodule

// File: rtl/rtc_irq_collector.sv
module rtc_irq_collector
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  ev_i,
    input  logic        batt_ok_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [1:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic        clk32k_i,
    output logic        irq1_pin_o,
    output logic        irq2_n_o
);
    // pulse channel indices
    localparam int PC_SEC  = 0;
    localparam int PC_TMA  = 1;
    localparam int PC_TMB1 = 2;
    localparam int PC_TMB2 = 3;

    typedef struct packed {
        logic [NSRC-1:0]   sw_clr;
        logic              rd_clr;
        logic [NPULSE-1:0] trig;
        logic [NSRC-1:0]   lvl;
        logic              irq1_act;
        logic              irq2_act;
    } comb_t;

    cfg_t              cfg;
    logic [NSRC-1:0]   flags;
    logic [NPULSE-1:0] pulse_act;
    comb_t             c;

    always_comb begin
        c = '0;
        c.sw_clr = (wr_en_i && addr_i == REG_FLAG) ? wdata_i : '0;
        c.rd_clr = rd_en_i && (addr_i == REG_FLAG);

        c.trig[PC_SEC]  = ev_i[SRC_SEC] && cfg.en[SRC_SEC] && cfg.mode[MD_PULSE_A];
        c.trig[PC_TMA]  = ev_i[SRC_TMA] && cfg.en[SRC_TMA] && cfg.mode[MD_PULSE_A];
        c.trig[PC_TMB1] = ev_i[SRC_TMB] && cfg.en[SRC_TMB] && cfg.mode[MD_PULSE_B];
        c.trig[PC_TMB2] = ev_i[SRC_TMB] && cfg.mode[MD_IRQ2_EN] && cfg.mode[MD_PULSE_B];

        c.lvl = flags & cfg.en;
        if (cfg.mode[MD_PULSE_A]) begin
            c.lvl[SRC_SEC] = pulse_act[PC_SEC];
            c.lvl[SRC_TMA] = pulse_act[PC_TMA];
        end
        if (cfg.mode[MD_PULSE_B])
            c.lvl[SRC_TMB] = pulse_act[PC_TMB1];
        c.irq1_act = |c.lvl;

        if (cfg.mode[MD_PULSE_B])
            c.irq2_act = pulse_act[PC_TMB2];
        else
            c.irq2_act = flags[SRC_TMB] && cfg.mode[MD_IRQ2_EN];
    end

    rtc_irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .flags_i (flags),
        .cfg_o   (cfg),
        .rdata_o (rdata_o)
    );

    rtc_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .sw_clr_i  (c.sw_clr),
        .rd_clr_i  (c.rd_clr),
        .batt_ok_i (batt_ok_i),
        .flags_o   (flags)
    );

    for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
        rtc_irq_pulse #(.CYCLES(PULSE_CYCLES)) u_pulse (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_i   (c.trig[g]),
            .active_o (pulse_act[g])
        );
    end

    assign irq1_pin_o = cfg.mode[MD_PIN_IRQ] ? ~c.irq1_act : clk32k_i;
    assign irq2_n_o   = ~c.irq2_act;
endmodule

// File: rtl/rtc_irq_collector_chk.sv
module rtc_irq_collector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ev_i,
    input logic       batt_ok_i,
    input logic       wr_en_i,
    input logic       rd_en_i,
    input logic [1:0] addr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] flags,
    input logic       irq2_n_o
);
    // R2: every strobed source has its flag set one edge later
    p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != 8'h00) |=> ((flags & $past(ev_i)) == $past(ev_i)));

    // R5: a clear write colliding with an event leaves the flag set
    p_clear_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd1 && (wdata_i & ev_i) != 8'h00)
        |=> ((flags & $past(wdata_i & ev_i)) == $past(wdata_i & ev_i)));

    // R6: reading the flag register drops the watchdog flag
    p_wdg_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd1 && !ev_i[2]) |=> !flags[2]);

    // R7: battery-low flag survives everything but the replacement strobe
    p_blo_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[6] && !batt_ok_i) |=> flags[6]);

    // R10: second interrupt only asserts after a countdown B event or a config write
    p_irq2_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq2_n_o) |-> ($past(ev_i[3]) || $past(wr_en_i)));
endmodule

bind rtc_irq_collector rtc_irq_collector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_i),
    .batt_ok_i (batt_ok_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flags     (flags),
    .irq2_n_o  (irq2_n_o)
);

// File: tb/sim_rtc_irq_collector.sv
`timescale 1ns/1ps
module sim_rtc_irq_collector;
    localparam int P = 4;

    localparam logic [2:0] K_NOP = 3'd0;
    localparam logic [2:0] K_EV  = 3'd1;
    localparam logic [2:0] K_WR  = 3'd2;
    localparam logic [2:0] K_RD  = 3'd3;
    localparam logic [2:0] K_BAT = 3'd4;

    localparam int NV = 31;
    // {kind, addr, data, check_rd, exp_rd, exp_pin, exp_irq2, req}
    localparam logic [27:0] TBL [NV] = '{
        {K_WR,  2'd2, 8'h04, 1'b0, 8'h00, 1'b1, 1'b1, 4'd11}, // R11 pin to irq
        {K_EV,  2'd0, 8'h10, 1'b0, 8'h00, 1'b1, 1'b1, 4'd2},  // R2 alarm not enabled
        {K_RD,  2'd1, 8'h00, 1'b1, 8'h10, 1'b1, 1'b1, 4'd12}, // R12 flags read
        {K_WR,  2'd0, 8'h10, 1'b0, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 enable alarm
        {K_WR,  2'd1, 8'h10, 1'b0, 8'h00, 1'b1, 1'b1, 4'd4},  // R4 clear alarm
        {K_WR,  2'd0, 8'h08, 1'b0, 8'h00, 1'b1, 1'b1, 4'd3},  // R3
        {K_WR,  2'd2, 8'h0C, 1'b0, 8'h00, 1'b1, 1'b1, 4'd10}, // R10 irq2 enable
        {K_EV,  2'd0, 8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 4'd10}, // R10 cntB both low
        {K_RD,  2'd2, 8'h00, 1'b1, 8'h0C, 1'b0, 1'b0, 4'd12}, // R12 mode read
        {K_WR,  2'd1, 8'h08, 1'b0, 8'h00, 1'b1, 1'b1, 4'd4},  // R4
        {K_WR,  2'd0, 8'h04, 1'b0, 8'h00, 1'b1, 1'b1, 4'd6},  // R6
        {K_EV,  2'd0, 8'h04, 1'b0, 8'h00, 1'b0, 1'b1, 4'd6},  // R6 watchdog
        {K_WR,  2'd1, 8'h04, 1'b0, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 bit2 ignored
        {K_RD,  2'd1, 8'h00, 1'b1, 8'h04, 1'b1, 1'b1, 4'd6},  // R6 read clears
        {K_RD,  2'd1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 4'd6},  // R6
        {K_WR,  2'd0, 8'h40, 1'b0, 8'h00, 1'b1, 1'b1, 4'd7},  // R7
        {K_EV,  2'd0, 8'h40, 1'b0, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 battery low
        {K_WR,  2'd1, 8'h40, 1'b0, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 write ignored
        {K_RD,  2'd1, 8'h00, 1'b1, 8'h40, 1'b0, 1'b1, 4'd7},  // R7
        {K_BAT, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 4'd7},  // R7 replaced
        {K_WR,  2'd0, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1, 4'd8},  // R8
        {K_EV,  2'd0, 8'h80, 1'b0, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 offset
        {K_NOP, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 4'd8},  // R8 one cycle
        {K_RD,  2'd3, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 4'd12}, // R12 addr 3
        {K_RD,  2'd0, 8'h00, 1'b1, 8'h80, 1'b1, 1'b1, 4'd12}, // R12 enables
        {K_WR,  2'd0, 8'h02, 1'b0, 8'h00, 1'b1, 1'b1, 4'd3},  // R3
        {K_EV,  2'd0, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 cntA level
        {K_WR,  2'd1, 8'h02, 1'b0, 8'h00, 1'b1, 1'b1, 4'd4},  // R4
        {K_WR,  2'd0, 8'h20, 1'b0, 8'h00, 1'b1, 1'b1, 4'd3},  // R3
        {K_EV,  2'd0, 8'h20, 1'b0, 8'h00, 1'b0, 1'b1, 4'd2},  // R2 switch-over
        {K_WR,  2'd1, 8'h20, 1'b0, 8'h00, 1'b1, 1'b1, 4'd4}   // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_i = '0;
    logic       batt_ok_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [1:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       clk32k_i = 1'b1;
    logic       irq1_pin_o;
    logic       irq2_n_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_irq_collector #(.PULSE_CYCLES(P)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_i),
        .batt_ok_i  (batt_ok_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .clk32k_i   (clk32k_i),
        .irq1_pin_o (irq1_pin_o),
        .irq2_n_o   (irq2_n_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle of stimulus, end at the next falling edge
    task automatic op(input logic [2:0] kind, input logic [1:0] a,
                      input logic [7:0] d, input logic [7:0] ev_extra);
        addr_i    = a;
        wdata_i   = d;
        wr_en_i   = (kind == K_WR);
        rd_en_i   = (kind == K_RD);
        batt_ok_i = (kind == K_BAT);
        ev_i      = ((kind == K_EV) ? d : 8'h00) | ev_extra;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0; rd_en_i = 1'b0; batt_ok_i = 1'b0; ev_i = '0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pin", {7'd0, irq1_pin_o}, 8'h01);
        chk("R1 irq2", {7'd0, irq2_n_o}, 8'h01);
        chk("R1 rdata", rdata_o, 8'h00);
        clk32k_i = 1'b0; #1;
        chk("R1 pin clk", {7'd0, irq1_pin_o}, 8'h00);
        clk32k_i = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        op(K_RD, 2'd0, 8'h00, 8'h00);
        chk("R1 enables", rdata_o, 8'h00);
        op(K_RD, 2'd2, 8'h00, 8'h00);
        chk("R1 mode", rdata_o, 8'h00);
        op(K_RD, 2'd1, 8'h00, 8'h00);
        chk("R1 flags", rdata_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = TBL[i];
            op(v[27:25], v[24:23], v[22:15], 8'h00);
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            chk({tag, " pin"}, {7'd0, irq1_pin_o}, {7'd0, v[5]});
            chk({tag, " irq2"}, {7'd0, irq2_n_o}, {7'd0, v[4]});
            if (v[14]) chk({tag, " rdata"}, rdata_o, v[13:6]);
        end

        // R9: pulse mode for the second tick
        op(K_WR, 2'd0, 8'h01, 8'h00);
        op(K_WR, 2'd2, 8'h05, 8'h00);
        op(K_EV, 2'd0, 8'h01, 8'h00);
        for (int k = 0; k < P; k++) begin
            if (k != 0) @(negedge clk);
            chk($sformatf("R9 pulse low cyc%0d", k), {7'd0, irq1_pin_o}, 8'h00);
        end
        @(negedge clk);
        chk("R9 pulse ended", {7'd0, irq1_pin_o}, 8'h01);
        op(K_RD, 2'd1, 8'h00, 8'h00);
        chk("R9 flag kept", rdata_o, 8'h01);

        // R5: clear collides with a new event on the same flag
        op(K_WR, 2'd1, 8'h01, 8'h01);
        op(K_RD, 2'd1, 8'h00, 8'h00);
        chk("R5 event beats clear", rdata_o, 8'h01);

        // R11: clock on the pin masks the interrupt, flags keep updating
        op(K_WR, 2'd0, 8'h10, 8'h00);
        op(K_EV, 2'd0, 8'h10, 8'h00);
        chk("R11 pre: irq on pin", {7'd0, irq1_pin_o}, 8'h00);
        op(K_WR, 2'd2, 8'h00, 8'h00);
        chk("R11 clk high", {7'd0, irq1_pin_o}, 8'h01);
        clk32k_i = 1'b0; #1;
        chk("R11 clk low", {7'd0, irq1_pin_o}, 8'h00);
        clk32k_i = 1'b1;
        op(K_EV, 2'd0, 8'h02, 8'h00);
        op(K_RD, 2'd1, 8'h00, 8'h00);
        chk("R11 flags update", rdata_o, 8'h13);

        // R10: countdown B pulse on the second output
        op(K_WR, 2'd2, 8'h0A, 8'h00);
        op(K_EV, 2'd0, 8'h08, 8'h00);
        for (int k = 0; k < P; k++) begin
            if (k != 0) @(negedge clk);
            chk($sformatf("R10 irq2 pulse cyc%0d", k), {7'd0, irq2_n_o}, 8'h00);
        end
        @(negedge clk);
        chk("R10 irq2 pulse ended", {7'd0, irq2_n_o}, 8'h01);
        op(K_EV, 2'd0, 8'h37, 8'h00);
        chk("R10 other sources", {7'd0, irq2_n_o}, 8'h01);
        op(K_RD, 2'd1, 8'h00, 8'h00);
        chk("R9 cntB flag kept", rdata_o, 8'h3F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule